// File: doc/BRIEF.md
# Dual Power-Mode-Aware Prescaler

This block holds two free-running up-counters whose bits give on-chip peripherals divided clock enables. The wide counter (13 bits) runs in the system clock domain. In the full-speed power modes it steps on every clock. In the medium-speed power modes it steps once per 8, 16, 32 or 64 clocks, chosen by a 2-bit ratio select. In every low-power mode it is held at zero.

The narrow counter (8 bits) is fed by a watch-clock tick. The tick is a one-cycle pulse in the system clock domain, one per watch-clock period. A 2-bit quarter stage divides the tick by four before it reaches the counter. The narrow counter and its quarter stage freeze only in standby. In every other mode they keep counting, which lets timekeeping peripherals run while the system clock domain idles.

For every counter bit there is a tap strobe. A tap is high for exactly one cycle when its bit falls from 1 to 0. Peripherals use the taps as clock enables. No software interface can read or write either counter.

Top module: `dual_prescaler`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both counters, the quarter stage and the medium-speed divider. All taps are zero after that edge.
- R2: In power modes 0 (fast run) and 2 (fast sleep), `sys_count` increases by one on every clock.
- R3: In power modes 1 (medium run) and 3 (medium sleep), `sys_count` steps once per 16, 32, 64 or 8 clocks for `ms_ratio` codes 00, 01, 10 or 11. The divider restarts from zero when a medium mode is entered, so the first step comes on the Nth clock in that mode.
- R4: In power modes 4 (standby), 5 (watch), 6 (sub run) and 7 (sub sleep), `sys_count` is cleared to zero and held there, and `sys_tap` stays zero.
- R5: In power mode 4, `wat_count` and the quarter stage keep their values and ignore `wclk_tick`. `wat_tap` stays zero.
- R6: In every mode other than 4, `wat_count` increases by one on every fourth `wclk_tick` pulse, including in modes 5, 6 and 7.
- R7: Bit k of a tap bus is high for exactly the cycle in which the matching counter output first shows a value where bit k has just fallen from 1 to 0 on a step. Otherwise that tap bit is zero.
- R8: Each counter wraps from all ones to zero. On the wrap step, all of its tap bits are high at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wclk_tick | input | 1 | One-cycle pulse per watch-clock period, synchronous to clk |
| pmode | input | 3 | Power mode: 0 fast run, 1 medium run, 2 fast sleep, 3 medium sleep, 4 standby, 5 watch, 6 sub run, 7 sub sleep |
| ms_ratio | input | 2 | Medium-speed ratio select: 00 /16, 01 /32, 10 /64, 11 /8 |
| sys_count | output | 13 | System prescaler value |
| sys_tap | output | 13 | Falling-bit strobes of sys_count |
| wat_count | output | 8 | Watch prescaler value |
| wat_tap | output | 8 | Falling-bit strobes of wat_count |

## Verification
The bench runs the system counter through one long full-speed stretch that crosses the 13-bit wrap. Watch ticks arrive on every cycle there, so the step rule and all-bits-set tap pattern of each counter are checked together. Each medium-speed ratio code then runs for several periods, and a mode exit and re-entry shows that the divider restarts from zero rather than keeping its old phase. Standby with ticks present is contrasted with watch, sub run and sub sleep modes, where ticks come every third cycle. This separates "system counter cleared while the watch counter holds" from "system counter cleared while the watch counter keeps stepping".

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;

  typedef enum logic [2:0] {
    PM_RUN_FAST   = 3'd0,
    PM_RUN_MED    = 3'd1,
    PM_SLEEP_FAST = 3'd2,
    PM_SLEEP_MED  = 3'd3,
    PM_STANDBY    = 3'd4,
    PM_WATCH      = 3'd5,
    PM_SUB_RUN    = 3'd6,
    PM_SUB_SLEEP  = 3'd7
  } pmode_e;

  // Modes that step the system counter through the medium-speed divider.
  function automatic logic is_medium(input pmode_e m);
    return (m == PM_RUN_MED) || (m == PM_SLEEP_MED);
  endfunction

  // Modes that hold the system counter at zero.
  function automatic logic sys_held_zero(input pmode_e m);
    return (m == PM_STANDBY) || (m == PM_WATCH) ||
           (m == PM_SUB_RUN) || (m == PM_SUB_SLEEP);
  endfunction

  // Modes that freeze the watch path.
  function automatic logic wat_frozen(input pmode_e m);
    return m == PM_STANDBY;
  endfunction

  // log2 of the medium-speed step period for each ratio code.
  function automatic int unsigned med_log2(input logic [1:0] r);
    case (r)
      2'b00:   return 4;
      2'b01:   return 5;
      2'b10:   return 6;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/med_step_gen.sv
module med_step_gen #(
  parameter int unsigned DIV_W = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic [1:0] ratio,
  output logic       step
);
  import prescaler_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] span_mask;

  always_comb begin
    span_mask = '0;
    for (int k = 0; k < DIV_W; k++) begin
      if (k < int'(med_log2(ratio))) span_mask[k] = 1'b1;
    end
  end

  assign step = enable && ((div_q & span_mask) == span_mask);

  always_ff @(posedge clk) begin
    if (rst || !enable) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/watch_quarter.sv
module watch_quarter #(
  parameter int unsigned Q_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic freeze,
  input  logic tick,
  output logic adv
);
  logic [Q_W-1:0] q;
  logic           live;

  assign live = tick && !freeze;
  assign adv  = live && (&q);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (live) q <= q + 1'b1;
  end
endmodule

// File: rtl/prescale_counter.sv
module prescale_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] count,
  output logic [W-1:0] tap
);
  // Bit k falls on an increment exactly when bits k..0 are all ones.
  function automatic logic [W-1:0] fall_mask(input logic [W-1:0] v);
    logic acc;
    logic [W-1:0] m;
    acc = 1'b1;
    for (int k = 0; k < W; k++) begin
      acc  = acc & v[k];
      m[k] = acc;
    end
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
      tap   <= '0;
    end else if (step) begin
      count <= count + 1'b1;
      tap   <= fall_mask(count);
    end else begin
      tap   <= '0;
    end
  end
endmodule

// File: rtl/dual_prescaler.sv
module dual_prescaler #(
  parameter int unsigned SYS_W     = 13,
  parameter int unsigned WAT_W     = 8,
  parameter int unsigned QUARTER_W = 2,
  parameter int unsigned MED_DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wclk_tick,
  input  logic [2:0]       pmode,
  input  logic [1:0]       ms_ratio,
  output logic [SYS_W-1:0] sys_count,
  output logic [SYS_W-1:0] sys_tap,
  output logic [WAT_W-1:0] wat_count,
  output logic [WAT_W-1:0] wat_tap
);
  import prescaler_pkg::*;

  pmode_e mode;
  logic   sys_clear;
  logic   sys_medium;
  logic   med_step;
  logic   sys_step;
  logic   wat_freeze;
  logic   wat_step;

  assign mode       = pmode_e'(pmode);
  assign sys_clear  = sys_held_zero(mode);
  assign sys_medium = is_medium(mode);
  assign wat_freeze = wat_frozen(mode);
  assign sys_step   = !sys_clear && (sys_medium ? med_step : 1'b1);

  med_step_gen #(.DIV_W(MED_DIV_W)) u_med (
    .clk    (clk),
    .rst    (rst),
    .enable (sys_medium),
    .ratio  (ms_ratio),
    .step   (med_step)
  );

  watch_quarter #(.Q_W(QUARTER_W)) u_quarter (
    .clk    (clk),
    .rst    (rst),
    .freeze (wat_freeze),
    .tick   (wclk_tick),
    .adv    (wat_step)
  );

  prescale_counter #(.W(SYS_W)) u_sys (
    .clk   (clk),
    .rst   (rst),
    .clear (sys_clear),
    .step  (sys_step),
    .count (sys_count),
    .tap   (sys_tap)
  );

  prescale_counter #(.W(WAT_W)) u_wat (
    .clk   (clk),
    .rst   (rst),
    .clear (1'b0),
    .step  (wat_step),
    .count (wat_count),
    .tap   (wat_tap)
  );
endmodule

// File: rtl/prescaler_checker.sv
module prescaler_checker #(
  parameter int unsigned SYS_W = 13,
  parameter int unsigned WAT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       pmode,
  input logic [SYS_W-1:0] sys_count,
  input logic [SYS_W-1:0] sys_tap,
  input logic [WAT_W-1:0] wat_count,
  input logic [WAT_W-1:0] wat_tap,
  input logic             sys_step,
  input logic             wat_step
);
  logic fast_mode, low_mode, standby;
  assign fast_mode = (pmode == 3'd0) || (pmode == 3'd2);
  assign low_mode  = pmode >= 3'd4;
  assign standby   = pmode == 3'd4;

  p_full_speed_r2: assert property (@(posedge clk) disable iff (rst)
    fast_mode |=> sys_count == SYS_W'($past(sys_count) + 1'b1));

  p_sys_cleared_r4: assert property (@(posedge clk) disable iff (rst)
    low_mode |=> (sys_count == '0) && (sys_tap == '0));

  p_no_step_low_r4: assert property (@(posedge clk) disable iff (rst)
    low_mode |-> !sys_step);

  p_wat_hold_r5: assert property (@(posedge clk) disable iff (rst)
    standby |=> $stable(wat_count) && (wat_tap == '0));

  p_wat_adv_r6: assert property (@(posedge clk) disable iff (rst)
    wat_step |=> wat_count == WAT_W'($past(wat_count) + 1'b1));

  p_sys_tap_low_r7: assert property (@(posedge clk) disable iff (rst)
    (sys_tap & sys_count) == '0);

  p_wat_tap_low_r7: assert property (@(posedge clk) disable iff (rst)
    (wat_tap & wat_count) == '0);
endmodule

bind dual_prescaler prescaler_checker #(.SYS_W(SYS_W), .WAT_W(WAT_W)) u_chk (.*);

// File: tb/dual_prescaler_test.sv
module dual_prescaler_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 13;
  localparam int WW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wclk_tick = 1'b0;
  logic [2:0]    pmode = 3'd0;
  logic [1:0]    ms_ratio = 2'b00;
  logic [SW-1:0] sys_count, sys_tap;
  logic [WW-1:0] wat_count, wat_tap;

  dual_prescaler uut (
    .clk(clk), .rst(rst), .wclk_tick(wclk_tick), .pmode(pmode),
    .ms_ratio(ms_ratio), .sys_count(sys_count), .sys_tap(sys_tap),
    .wat_count(wat_count), .wat_tap(wat_tap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [SW-1:0] s_cnt;
    logic [SW-1:0] s_tap;
    logic [WW-1:0] w_cnt;
    logic [WW-1:0] w_tap;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  // reference state
  int unsigned m_sys = 0, m_wat = 0, m_quarter = 0, m_div = 0;

  function automatic int unsigned period_of(input logic [1:0] r);
    case (r)
      2'b00: return 16;
      2'b01: return 32;
      2'b10: return 64;
      default: return 8;
    endcase
  endfunction

  task automatic drive(input logic r, input logic [2:0] m, input logic [1:0] ratio,
                       input logic tk, input string tag);
    exp_t e;
    int unsigned old_s, old_w;
    bit s_adv, w_adv;
    @(negedge clk);
    rst = r; pmode = m; ms_ratio = ratio; wclk_tick = tk;
    old_s = m_sys; old_w = m_wat;
    s_adv = 0; w_adv = 0;
    if (r) begin
      m_sys = 0; m_wat = 0; m_quarter = 0; m_div = 0;
    end else begin
      if (m == 3'd1 || m == 3'd3) begin
        s_adv = (m_div % period_of(ratio)) == period_of(ratio) - 1;
        m_div = (m_div + 1) % 64;
      end else begin
        m_div = 0;
        s_adv = (m == 3'd0 || m == 3'd2);
      end
      if (m >= 3'd4) m_sys = 0;
      else if (s_adv) m_sys = (m_sys + 1) % (1 << SW);
      if (m != 3'd4 && tk) begin
        w_adv = (m_quarter == 3);
        m_quarter = (m_quarter + 1) % 4;
        if (w_adv) m_wat = (m_wat + 1) % (1 << WW);
      end
    end
    e.s_cnt = m_sys[SW-1:0];
    e.w_cnt = m_wat[WW-1:0];
    e.s_tap = s_adv ? SW'(old_s & ~m_sys) : '0;
    e.w_tap = w_adv ? WW'(old_w & ~m_wat) : '0;
    e.tag = tag;
    if (e.s_tap == {SW{1'b1}} || e.w_tap == {WW{1'b1}}) e.tag = {tag, " R8"};
    sb.push_back(e);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (sys_count !== e.s_cnt || sys_tap !== e.s_tap ||
            wat_count !== e.w_cnt || wat_tap !== e.w_tap) begin
          failures++;
          $display("FAIL %s: got sys=%h tap=%h wat=%h wtap=%h exp sys=%h tap=%h wat=%h wtap=%h",
                   e.tag, sys_count, sys_tap, wat_count, wat_tap,
                   e.s_cnt, e.s_tap, e.w_cnt, e.w_tap);
        end
      end
    end
  end

  // watchdog
  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog: got cycles=%0d exp below 150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    // R1 reset state
    for (int i = 0; i < 3; i++) drive(1'b1, 3'd0, 2'b00, 1'b1, "R1");
    // R2 R6 R7 R8: full speed long enough to wrap both counters
    for (int i = 0; i < 8300; i++) drive(1'b0, 3'd0, 2'b00, 1'b1, "R2 R6 R7");
    // R3 medium run, every ratio code
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 200; i++) drive(1'b0, 3'd1, 2'(r), (i % 2) == 0, "R3 R7");
    // R2 fast sleep, then R3 re-entry restarts divider
    for (int i = 0; i < 37; i++) drive(1'b0, 3'd2, 2'b00, 1'b0, "R2");
    for (int i = 0; i < 140; i++) drive(1'b0, 3'd3, 2'b11, 1'b0, "R3");
    for (int i = 0; i < 5; i++)  drive(1'b0, 3'd0, 2'b11, 1'b0, "R2");
    for (int i = 0; i < 140; i++) drive(1'b0, 3'd3, 2'b01, 1'b1, "R3");
    // R4 R5 standby with ticks present
    for (int i = 0; i < 60; i++) drive(1'b0, 3'd4, 2'b00, 1'b1, "R4 R5");
    // R4 R6 other low-power modes keep the watch path running
    for (int m = 5; m < 8; m++)
      for (int i = 0; i < 120; i++) drive(1'b0, 3'(m), 2'b10, (i % 3) == 0, "R4 R6");
    // recovery and a mid-run reset
    for (int i = 0; i < 50; i++) drive(1'b0, 3'd0, 2'b00, 1'b1, "R2 R6");
    drive(1'b1, 3'd0, 2'b00, 1'b1, "R1");
    for (int i = 0; i < 20; i++) drive(1'b0, 3'd1, 2'b11, 1'b1, "R3 R6");
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule